// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access may proceed once the page-table entry for its address has been located. It merges two independent sources of protection. The first is a three-bit page-protection code in the entry, which is read through one of two tables depending on a key bit taken from the segment. The second is a per-key authority mask held in a 64-bit register, which can withdraw load or store rights for each of 32 page keys. The block returns the rights that are granted, a fault flag, a fault-cause word and a bit that says whether the fault goes to the hypervisor.

Each request is presented for one cycle with `req_valid`. The response appears on the outputs one clock edge later and stays there for exactly one cycle. The mask register is loaded through a one-cycle write strobe. Once a load or fetch has been granted, the write right is withheld from the returned rights. A later store to the same page then comes back through the check, and the caller can mark the page as changed at that point.

Top module: `page_perm_check`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_rights`, `rsp_fault`, `rsp_status` and `rsp_to_hv` are all zero and the authority mask register holds zero, so no key is restricted.
- R2: The effective key is `seg_key_user` when `req_prob` is 1 and `seg_key_sup` when `req_prob` is 0.
- R3: The page code is `{pte_pp_hi, pte_pp}`. With effective key 0, codes 0, 1 and 2 give read and write, codes 3 and 6 give read only, and codes 4, 5 and 7 give nothing. Rights are encoded as bit 0 read, bit 1 write and bit 2 execute.
- R4: With effective key 1, codes 0 and 6 give nothing, codes 1 and 3 give read only, code 2 gives read and write, and codes 4, 5 and 7 give nothing.
- R5: Execute right is withheld if any of `pte_noexec`, `pte_guard` or `seg_noexec` is 1.
- R6: When `mask_en` is 1, the two mask bits for key k sit at bit positions 2*(31-k)+1 (store deny) and 2*(31-k) (load deny). When `mask_en` is 0, the mask withdraws no right. The mask never withdraws execute.
- R7: The access type on `req_acc` is 0 for a load (needs read), 1 for a store (needs write), 2 for a fetch (needs execute), and 3 is handled as a load. The request faults when the needed right is missing from the page rights ANDed with the mask rights. A faulting response returns zero rights.
- R8: For a rejected load or store, the status word ORs 0x08000000 if the page rights lack the needed right, 0x02000000 for a store, and 0x00200000 if the mask rights lack it. A rejected fetch reports 0x08000000. A granted access reports status 0.
- R9: Priority is as follows. A fetch with `seg_noexec` set faults first with status 0x10000000. Otherwise, `pte_found` equal to 0 faults with 0x40000000, ORed with 0x02000000 for a store. Only after these are the rights checked.
- R10: `rsp_to_hv` is 1 exactly when the response faults, `vpm1_ctl` is 1 and `hv_state` is 0.
- R11: A granted access that is not a store returns the write right as 0. A granted store returns it as given by the rights.
- R12: The response appears one cycle after a request. `rsp_valid` follows `req_valid` one cycle later, and all response outputs are zero in a cycle where `rsp_valid` is 0.
- R13: A mask write becomes visible to requests from the next cycle on. A request in the same cycle as a write is checked against the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 as load |
| req_prob | input | 1 | Problem (user) state |
| seg_key_user | input | 1 | Segment key used in problem state |
| seg_key_sup | input | 1 | Segment key used in supervisor state |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| pte_found | input | 1 | A matching page-table entry exists |
| pte_pp | input | 2 | Low page-protection bits |
| pte_pp_hi | input | 1 | High page-protection bit |
| pte_noexec | input | 1 | Entry forbids execution |
| pte_guard | input | 1 | Entry is guarded |
| pte_key | input | 5 | Entry's authority-mask key |
| mask_en | input | 1 | Authority mask protection enabled |
| vpm1_ctl | input | 1 | Route translated-mode faults to hypervisor |
| hv_state | input | 1 | Processor is in hypervisor state |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 64 | New mask register value |
| rsp_valid | output | 1 | Response present |
| rsp_rights | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |
| rsp_fault | output | 1 | Access rejected |
| rsp_status | output | 32 | Fault-cause word |
| rsp_to_hv | output | 1 | Fault goes to the hypervisor |

## Verification
The bench builds the block with its defaults of 32 keys and a 64-bit mask, so every key's slice of the register can be reached. Directed sweeps cover keys 0, 17 and 31. Random mask contents are combined with random keys across the whole key range. At this size both ends of the reversed bit mapping are visible, and every one of the eight page codes is exercised under both key values.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int RT_R = 0;
    localparam int RT_W = 1;
    localparam int RT_X = 2;

    localparam logic [31:0] ST_PAGE_DENY = 32'h0800_0000;
    localparam logic [31:0] ST_IS_STORE  = 32'h0200_0000;
    localparam logic [31:0] ST_MASK_DENY = 32'h0020_0000;
    localparam logic [31:0] ST_NO_ENTRY  = 32'h4000_0000;
    localparam logic [31:0] ST_SEG_NX    = 32'h1000_0000;

    typedef struct packed {
        logic        valid;
        logic [2:0]  rights;
        logic        fault;
        logic [31:0] status;
        logic        to_hv;
    } rsp_t;

endpackage

// File: rtl/perm_pp_decode.sv
module perm_pp_decode
    import page_perm_pkg::*;
(
    input  logic       eff_key,
    input  logic [2:0] pp_code,
    input  logic       pte_nx,
    input  logic       pte_g,
    input  logic       seg_nx,
    output logic [2:0] rights
);
    logic rd, wr;

    always_comb begin
        rd = 1'b0;
        wr = 1'b0;
        if (!eff_key) begin
            unique case (pp_code)
                3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
                3'd3, 3'd6:       rd = 1'b1;
                default:          ;
            endcase
        end else begin
            unique case (pp_code)
                3'd1, 3'd3: rd = 1'b1;
                3'd2:       begin rd = 1'b1; wr = 1'b1; end
                default:    ;
            endcase
        end
        rights        = '0;
        rights[RT_R]  = rd;
        rights[RT_W]  = wr;
        rights[RT_X]  = ~(pte_nx | pte_g | seg_nx);
    end
endmodule

// File: rtl/perm_key_mask.sv
module perm_key_mask
    import page_perm_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    localparam int KEY_W   = $clog2(NUM_KEYS),
    localparam int MASK_W  = 2 * NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MASK_W-1:0] wdata,
    input  logic              en,
    input  logic [KEY_W-1:0]  key_sel,
    output logic [2:0]        rights
);
    logic [MASK_W-1:0] mask_d, mask_q;
    logic [1:0]        slot [NUM_KEYS];
    logic [1:0]        sel_bits;

    // Key k owns the pair counted from the top of the register.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
        assign slot[k] = mask_q[2*(NUM_KEYS-1-k) +: 2];
    end

    assign sel_bits = slot[key_sel];

    always_comb begin
        mask_d = mask_q;
        if (we) mask_d = wdata;
        rights       = 3'b111;
        if (en) begin
            rights[RT_R] = ~sel_bits[0];
            rights[RT_W] = ~sel_bits[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/perm_fault_encode.sv
module perm_fault_encode
    import page_perm_pkg::*;
(
    input  logic [1:0]  acc,
    input  logic        seg_nx,
    input  logic        found,
    input  logic [2:0]  page_rights,
    input  logic [2:0]  mask_rights,
    output logic        fault,
    output logic [31:0] status,
    output logic [2:0]  granted
);
    acc_e       acc_v;
    logic [2:0] need;
    logic [2:0] prot;
    logic       is_store, is_fetch;

    assign acc_v    = acc_e'(acc);
    assign is_store = (acc_v == ACC_STORE);
    assign is_fetch = (acc_v == ACC_FETCH);
    assign prot     = page_rights & mask_rights;

    always_comb begin
        need = '0;
        unique case (acc_v)
            ACC_STORE: need[RT_W] = 1'b1;
            ACC_FETCH: need[RT_X] = 1'b1;
            default:   need[RT_R] = 1'b1;
        endcase
    end

    always_comb begin
        fault  = 1'b0;
        status = '0;
        if (is_fetch && seg_nx) begin
            fault  = 1'b1;
            status = ST_SEG_NX;
        end else if (!found) begin
            fault  = 1'b1;
            status = ST_NO_ENTRY | (is_store ? ST_IS_STORE : 32'h0);
        end else if ((need & ~prot) != 3'b000) begin
            fault = 1'b1;
            if (is_fetch) begin
                status = ST_PAGE_DENY;
            end else begin
                if ((need & ~page_rights) != 3'b000) status = status | ST_PAGE_DENY;
                if (is_store)                        status = status | ST_IS_STORE;
                if ((need & ~mask_rights) != 3'b000) status = status | ST_MASK_DENY;
            end
        end
        granted = prot;
        if (!is_store) granted[RT_W] = 1'b0;
        if (fault)     granted = '0;
    end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import page_perm_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    localparam int KEY_W   = $clog2(NUM_KEYS),
    localparam int MASK_W  = 2 * NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_acc,
    input  logic              req_prob,
    input  logic              seg_key_user,
    input  logic              seg_key_sup,
    input  logic              seg_noexec,
    input  logic              pte_found,
    input  logic [1:0]        pte_pp,
    input  logic              pte_pp_hi,
    input  logic              pte_noexec,
    input  logic              pte_guard,
    input  logic [KEY_W-1:0]  pte_key,
    input  logic              mask_en,
    input  logic              vpm1_ctl,
    input  logic              hv_state,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_rights,
    output logic              rsp_fault,
    output logic [31:0]       rsp_status,
    output logic              rsp_to_hv
);
    logic        eff_key;
    logic [2:0]  page_rights, mask_rights, granted;
    logic        flt;
    logic [31:0] flt_status;
    rsp_t        rsp_d, rsp_q;

    assign eff_key = req_prob ? seg_key_user : seg_key_sup;

    perm_pp_decode u_pp (
        .eff_key (eff_key),
        .pp_code ({pte_pp_hi, pte_pp}),
        .pte_nx  (pte_noexec),
        .pte_g   (pte_guard),
        .seg_nx  (seg_noexec),
        .rights  (page_rights)
    );

    perm_key_mask #(.NUM_KEYS(NUM_KEYS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mask_we),
        .wdata   (mask_wdata),
        .en      (mask_en),
        .key_sel (pte_key),
        .rights  (mask_rights)
    );

    perm_fault_encode u_enc (
        .acc         (req_acc),
        .seg_nx      (seg_noexec),
        .found       (pte_found),
        .page_rights (page_rights),
        .mask_rights (mask_rights),
        .fault       (flt),
        .status      (flt_status),
        .granted     (granted)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.rights = granted;
            rsp_d.fault  = flt;
            rsp_d.status = flt_status;
            rsp_d.to_hv  = flt & vpm1_ctl & ~hv_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_rights = rsp_q.rights;
    assign rsp_fault  = rsp_q.fault;
    assign rsp_status = rsp_q.status;
    assign rsp_to_hv  = rsp_q.to_hv;
endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_acc,
    input logic        seg_noexec,
    input logic        pte_found,
    input logic        pte_noexec,
    input logic        pte_guard,
    input logic        vpm1_ctl,
    input logic        hv_state,
    input logic        rsp_valid,
    input logic [2:0]  rsp_rights,
    input logic        rsp_fault,
    input logic [31:0] rsp_status,
    input logic        rsp_to_hv
);
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rights == 3'b000 && !rsp_fault && rsp_status == 32'h0 && !rsp_to_hv));
    p_fault_no_rights_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_rights == 3'b000);
    p_granted_zero_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_status == 32'h0);
    p_exec_denied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (pte_noexec || pte_guard || seg_noexec)) |=> !rsp_rights[2]);
    p_no_write_unless_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != 2'd1) |=> !rsp_rights[1]);
    p_missing_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pte_found && !(req_acc == 2'd2 && seg_noexec)) |=> (rsp_fault && rsp_status[30]));
    p_hv_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!vpm1_ctl || hv_state)) |=> !rsp_to_hv);
    p_hv_needs_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_to_hv |-> rsp_fault);
endmodule

bind page_perm_check page_perm_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_acc    (req_acc),
    .seg_noexec (seg_noexec),
    .pte_found  (pte_found),
    .pte_noexec (pte_noexec),
    .pte_guard  (pte_guard),
    .vpm1_ctl   (vpm1_ctl),
    .hv_state   (hv_state),
    .rsp_valid  (rsp_valid),
    .rsp_rights (rsp_rights),
    .rsp_fault  (rsp_fault),
    .rsp_status (rsp_status),
    .rsp_to_hv  (rsp_to_hv)
);

// File: tb/page_perm_check_bench.sv
module page_perm_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_acc = 2'd0;
    logic        req_prob = 1'b0;
    logic        seg_key_user = 1'b0;
    logic        seg_key_sup = 1'b0;
    logic        seg_noexec = 1'b0;
    logic        pte_found = 1'b1;
    logic [1:0]  pte_pp = 2'd0;
    logic        pte_pp_hi = 1'b0;
    logic        pte_noexec = 1'b0;
    logic        pte_guard = 1'b0;
    logic [4:0]  pte_key = 5'd0;
    logic        mask_en = 1'b0;
    logic        vpm1_ctl = 1'b0;
    logic        hv_state = 1'b0;
    logic        mask_we = 1'b0;
    logic [63:0] mask_wdata = 64'h0;
    logic        rsp_valid;
    logic [2:0]  rsp_rights;
    logic        rsp_fault;
    logic [31:0] rsp_status;
    logic        rsp_to_hv;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [63:0] m_mask   = 64'h0;

    always #5 clk = ~clk;

    page_perm_check u_page_perm_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
        .req_prob(req_prob), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
        .seg_noexec(seg_noexec), .pte_found(pte_found), .pte_pp(pte_pp),
        .pte_pp_hi(pte_pp_hi), .pte_noexec(pte_noexec), .pte_guard(pte_guard),
        .pte_key(pte_key), .mask_en(mask_en), .vpm1_ctl(vpm1_ctl), .hv_state(hv_state),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .rsp_valid(rsp_valid),
        .rsp_rights(rsp_rights), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rsp_to_hv(rsp_to_hv)
    );

    // Expected {valid, rights, fault, status, to_hv} from the requirements.
    function automatic logic [37:0] model();
        logic        k;
        logic [2:0]  code, pr, mr, need, pm;
        logic [1:0]  mb;
        logic        f;
        logic [31:0] st;
        logic [2:0]  g;
        if (!req_valid) return 38'h0;
        k    = req_prob ? seg_key_user : seg_key_sup;
        code = {pte_pp_hi, pte_pp};
        pr   = 3'b000;
        if (k == 1'b0) begin
            if (code <= 3'd2)                    pr[1:0] = 2'b11;
            else if (code == 3'd3 || code == 3'd6) pr[1:0] = 2'b01;
        end else begin
            if (code == 3'd2)                    pr[1:0] = 2'b11;
            else if (code == 3'd1 || code == 3'd3) pr[1:0] = 2'b01;
        end
        pr[2] = !(pte_noexec || pte_guard || seg_noexec);
        mb    = m_mask[2*(31-pte_key) +: 2];
        mr    = mask_en ? {1'b1, !mb[1], !mb[0]} : 3'b111;
        need  = (req_acc == 2'd1) ? 3'b010 : (req_acc == 2'd2) ? 3'b100 : 3'b001;
        pm    = pr & mr;
        f     = 1'b1;
        st    = 32'h0;
        if (req_acc == 2'd2 && seg_noexec) st = 32'h1000_0000;
        else if (!pte_found) st = 32'h4000_0000 | ((req_acc == 2'd1) ? 32'h0200_0000 : 32'h0);
        else if ((need & ~pm) != 0) begin
            if (req_acc == 2'd2) st = 32'h0800_0000;
            else begin
                if ((need & ~pr) != 0) st |= 32'h0800_0000;
                if (req_acc == 2'd1)   st |= 32'h0200_0000;
                if ((need & ~mr) != 0) st |= 32'h0020_0000;
            end
        end else f = 1'b0;
        g = pm;
        if (req_acc != 2'd1) g[1] = 1'b0;
        if (f) g = 3'b000;
        return {1'b1, g, f, st, f & vpm1_ctl & !hv_state};
    endfunction

    task automatic compare(input string tag, input logic [37:0] exp);
        logic [37:0] got;
        got = {rsp_valid, rsp_rights, rsp_fault, rsp_status, rsp_to_hv};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got v=%b r=%b f=%b st=%h hv=%b, expected v=%b r=%b f=%b st=%h hv=%b",
                     tag, got[37], got[36:34], got[33], got[32:1], got[0],
                     exp[37], exp[36:34], exp[33], exp[32:1], exp[0]);
        end
    endtask

    // Inputs are already set at a falling edge; check after the next one.
    task automatic step(input string tag);
        logic [37:0] exp;
        exp = model();
        @(negedge clk);
        compare(tag, exp);
    endtask

    task automatic setr(input logic [1:0] acc, input logic [2:0] code, input logic key,
                        input logic [4:0] pkey, input logic en);
        req_valid = 1'b1; req_acc = acc; req_prob = 1'b0;
        seg_key_sup = key; seg_key_user = key;
        {pte_pp_hi, pte_pp} = code; pte_key = pkey; mask_en = en;
        seg_noexec = 1'b0; pte_noexec = 1'b0; pte_guard = 1'b0; pte_found = 1'b1;
        vpm1_ctl = 1'b0; hv_state = 1'b0;
    endtask

    task automatic write_mask(input logic [63:0] v);
        req_valid = 1'b0; mask_we = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0; m_mask = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        compare("R1", 38'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", 38'h0);
        // Mask resets to zero: every key unrestricted with mask enabled.
        setr(2'd1, 3'd0, 1'b0, 5'd31, 1'b1); step("R1");
        setr(2'd0, 3'd0, 1'b0, 5'd0, 1'b1);  step("R1");

        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 3; a++) begin
                setr(2'(a), 3'(c), 1'b0, 5'd3, 1'b0); step("R3");
                setr(2'(a), 3'(c), 1'b1, 5'd3, 1'b0); step("R4");
            end
        end

        // R2: key source selected by problem state.
        setr(2'd1, 3'd1, 1'b0, 5'd0, 1'b0);
        req_prob = 1'b1; seg_key_user = 1'b1; seg_key_sup = 1'b0; step("R2");
        req_prob = 1'b0; step("R2");
        req_prob = 1'b1; seg_key_user = 1'b0; seg_key_sup = 1'b1; step("R2");

        // R5: each execute blocker alone.
        setr(2'd2, 3'd2, 1'b0, 5'd0, 1'b0); step("R5");
        pte_noexec = 1'b1; step("R5");
        pte_noexec = 1'b0; pte_guard = 1'b1; step("R5");

        // R6: bit positions at both ends and the middle of the key range.
        write_mask(64'h8000_0000_0000_0000);
        setr(2'd1, 3'd0, 1'b0, 5'd0, 1'b1); step("R6");
        setr(2'd0, 3'd0, 1'b0, 5'd0, 1'b1); step("R6");
        setr(2'd1, 3'd0, 1'b0, 5'd1, 1'b1); step("R6");
        write_mask(64'h0000_0000_0000_0001);
        setr(2'd0, 3'd0, 1'b0, 5'd31, 1'b1); step("R6");
        setr(2'd1, 3'd0, 1'b0, 5'd31, 1'b1); step("R6");
        setr(2'd0, 3'd0, 1'b0, 5'd31, 1'b0); step("R6");
        write_mask(64'h3 << (2*(31-17)));
        setr(2'd1, 3'd0, 1'b0, 5'd17, 1'b1); step("R6");
        setr(2'd2, 3'd0, 1'b0, 5'd17, 1'b1); step("R6");

        // R8: both page and mask deny a store.
        setr(2'd1, 3'd3, 1'b0, 5'd17, 1'b1); step("R8");
        setr(2'd2, 3'd2, 1'b0, 5'd0, 1'b0); pte_guard = 1'b1; step("R8");

        // R9: priority of segment no-execute over missing entry.
        setr(2'd2, 3'd0, 1'b0, 5'd0, 1'b0); seg_noexec = 1'b1; pte_found = 1'b0; step("R9");
        setr(2'd1, 3'd0, 1'b0, 5'd0, 1'b0); pte_found = 1'b0; step("R9");
        setr(2'd0, 3'd0, 1'b0, 5'd0, 1'b0); pte_found = 1'b0; seg_noexec = 1'b1; step("R9");

        // R10: routing combinations on a fault and on a grant.
        setr(2'd0, 3'd7, 1'b0, 5'd0, 1'b0); vpm1_ctl = 1'b1; step("R10");
        hv_state = 1'b1; step("R10");
        setr(2'd0, 3'd0, 1'b0, 5'd0, 1'b0); vpm1_ctl = 1'b1; step("R10");

        // R11: load of a writable page drops write; store keeps it.
        setr(2'd0, 3'd2, 1'b1, 5'd0, 1'b0); step("R11");
        setr(2'd3, 3'd2, 1'b1, 5'd0, 1'b0); step("R11");
        setr(2'd1, 3'd2, 1'b1, 5'd0, 1'b0); step("R11");

        // R12: idle cycle clears the response.
        req_valid = 1'b0; step("R12");

        // R13: request in the write cycle sees the old mask.
        write_mask(64'h0);
        setr(2'd0, 3'd0, 1'b0, 5'd5, 1'b1);
        mask_we = 1'b1; mask_wdata = 64'h1 << (2*(31-5));
        step("R13");
        mask_we = 1'b0; m_mask = mask_wdata;
        step("R13");

        // Random mix checked against the model (R7).
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                write_mask({$urandom(), $urandom()});
            end
            req_valid    = ($urandom_range(0, 7) != 0);
            req_acc      = 2'($urandom());
            req_prob     = 1'($urandom());
            seg_key_user = 1'($urandom());
            seg_key_sup  = 1'($urandom());
            seg_noexec   = ($urandom_range(0, 7) == 0);
            pte_found    = ($urandom_range(0, 7) != 0);
            {pte_pp_hi, pte_pp} = 3'($urandom());
            pte_noexec   = 1'($urandom());
            pte_guard    = ($urandom_range(0, 3) == 0);
            pte_key      = 5'($urandom());
            mask_en      = 1'($urandom());
            vpm1_ctl     = 1'($urandom());
            hv_state     = 1'($urandom());
            step("R7");
        end

        req_valid = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule